// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block folds three sticky core events (a completion event, a continuous-test fault and an entropy health-test fault) into one interrupt line. It works in two stages. At the core stage each event flag has its own enable, and the enabled flags are ORed into a single core bit. At the top stage that core bit sits beside a slave-error bit in a write-one-to-clear status register. A mask register suppresses either bit. The mask can only be changed through a pair of write-only registers: one clears mask bits and the other sets them.

The two fault events come from an injection port. A fault is only taken when the oscillator is enabled, reseeding from the noise source is enabled, and neither the block reset nor the soft reset is active. A legacy-behaviour input adds one more condition to the continuous-test fault. It is taken only if its own explicit enable input is also high. The registers are reached through a simple write port and a combinational read port. Decoding a wider register bus is left to the surrounding logic.

Top module: `intAggTop`

## Requirements
- R1: After reset the enables, core flags and top status read zero, the mask reads 3, and `irq` is low.
- R2: Core flags are sticky. Flag bit 0 (done) is set by `doneEvt` with no other condition. Bit 1 (continuous fault) and bit 2 (health fault) are set by their injection inputs.
- R3: Writing the control register (address 0) with bit 3, 4 or 5 set clears core flag 0, 1 or 2. If a set event arrives in the same cycle, the set wins. Bits 2:0 of that write load the enables for flags 0 to 2.
- R4: Top status bit 0 (core bit) becomes the OR of (flag AND enable) whenever a flag or an enable changes. Otherwise it holds, and writing 1 to it clears it.
- R5: The top status register (address 2) is write-one-to-clear. Bit 0 is the core bit and bit 1 is the slave error, which `slvErrEvt` sets. A set in the same cycle wins over the clear.
- R6: The mask (address 3) is read-only and writes to it are ignored. Writing address 4 clears the mask bits written as 1. Writing address 5 sets them. Addresses 4 and 5 read as zero.
- R7: `irq` is registered. It equals the OR of (top status AND NOT mask) as it stood after the previous clock edge, so it changes one clock after the write or event that causes it.
- R8: An injected fault has no effect unless `oscEnable` and `reseedEnable` are high and both `blockReset` and `softReset` are low.
- R9: When `legacyMode` is high, a continuous-test fault is taken only if `legacyContEn` is also high. The health fault is not affected.
- R10: While `softReset` is high, the core flags and the core bit are cleared. The enables and the mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 6 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 3 | Read data (combinational) |
| doneEvt | input | 1 | Completion event pulse |
| contFaultInj | input | 1 | Continuous-test fault injection |
| healthFaultInj | input | 1 | Health-test fault injection |
| slvErrEvt | input | 1 | Slave error event pulse |
| oscEnable | input | 1 | Oscillator enabled |
| reseedEnable | input | 1 | Reseed from noise source enabled |
| blockReset | input | 1 | Block-level reset held active |
| softReset | input | 1 | Soft reset of the event logic |
| legacyMode | input | 1 | Select version-1 fault acceptance |
| legacyContEn | input | 1 | Explicit continuous-test enable for legacy mode |
| irq | output | 1 | Interrupt line |

## Verification
Some rules are checked by assertions on every cycle. They cover: a cleared or gated flag staying low, a flag staying set while nothing clears it, soft reset emptying the flags and the core bit, an unmask write taking effect, and `irq` staying low under a full mask. Other behaviour can only be shown by bench scenarios. These include whether the core bit is recomputed or held when a flag or an enable changes, which of a clear and a set wins when they coincide, that mask writes are ignored, and the exact cycle in which `irq` rises and falls after a write. The bench drives a table of enable, event and gating combinations, and then directed sequences for these cases.

// File: rtl/intAggPkg.sv
package intAggPkg;
  localparam int NUM_CORE = 3;
  localparam int NUM_TOP  = 2;
  localparam int CTRL_W   = 2 * NUM_CORE;

  localparam int ADR_CTRL    = 0;
  localparam int ADR_FLAGS   = 1;
  localparam int ADR_TOP     = 2;
  localparam int ADR_MASK    = 3;
  localparam int ADR_UNMASK  = 4;
  localparam int ADR_MASKSET = 5;

  typedef struct packed {
    logic                ctrlWr;
    logic [NUM_CORE-1:0] enVal;
    logic [NUM_CORE-1:0] clrFlags;
    logic [NUM_CORE-1:0] setFlags;
    logic [NUM_TOP-1:0]  w1cTop;
    logic [NUM_TOP-1:0]  unmask;
    logic [NUM_TOP-1:0]  maskSet;
    logic                slvSet;
    logic                softClr;
  } aggStrobes_t;
endpackage

// File: rtl/intAggControl.sv
module intAggControl
  import intAggPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              doneEvt,
  input  logic              contFaultInj,
  input  logic              healthFaultInj,
  input  logic              slvErrEvt,
  input  logic              oscEnable,
  input  logic              reseedEnable,
  input  logic              blockReset,
  input  logic              softReset,
  input  logic              legacyMode,
  input  logic              legacyContEn,
  output aggStrobes_t       stb
);
  logic faultOk;
  logic contOk;

  always_comb begin
    faultOk = oscEnable & reseedEnable & ~blockReset & ~softReset;
    contOk  = faultOk & (~legacyMode | legacyContEn);

    stb          = '0;
    stb.setFlags = {healthFaultInj & faultOk, contFaultInj & contOk, doneEvt};
    stb.slvSet   = slvErrEvt;
    stb.softClr  = softReset;

    if (wrEn) begin
      if (wrAddr == ADDR_W'(ADR_CTRL)) begin
        stb.ctrlWr   = 1'b1;
        stb.enVal    = wrData[NUM_CORE-1:0];
        stb.clrFlags = wrData[CTRL_W-1:NUM_CORE];
      end
      if (wrAddr == ADDR_W'(ADR_TOP))     stb.w1cTop  = wrData[NUM_TOP-1:0];
      if (wrAddr == ADDR_W'(ADR_UNMASK))  stb.unmask  = wrData[NUM_TOP-1:0];
      if (wrAddr == ADDR_W'(ADR_MASKSET)) stb.maskSet = wrData[NUM_TOP-1:0];
    end
  end
endmodule

// File: rtl/intAggDatapath.sv
module intAggDatapath
  import intAggPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  aggStrobes_t         stb,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [NUM_CORE-1:0] rdData,
  output logic [NUM_CORE-1:0] coreFlags,
  output logic                irq
);
  logic [NUM_CORE-1:0] flags, flagsNext;
  logic [NUM_CORE-1:0] en, enNext;
  logic                coreBit, coreNext;
  logic                slvBit, slvNext;
  logic [NUM_TOP-1:0]  mask, maskNext;
  logic [NUM_TOP-1:0]  topStatus;

  assign topStatus = {slvBit, coreBit};
  assign coreFlags = flags;

  always_comb begin
    flagsNext = stb.softClr ? '0 : ((flags & ~stb.clrFlags) | stb.setFlags);
    enNext    = stb.ctrlWr ? stb.enVal : en;
    if (stb.softClr)
      coreNext = 1'b0;
    else if ((flagsNext != flags) || (enNext != en))
      coreNext = |(flagsNext & enNext);
    else
      coreNext = coreBit & ~stb.w1cTop[0];
    slvNext  = stb.slvSet | (slvBit & ~stb.w1cTop[1]);
    maskNext = (mask & ~stb.unmask) | stb.maskSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      en      <= '0;
      coreBit <= 1'b0;
      slvBit  <= 1'b0;
      mask    <= '1;
      irq     <= 1'b0;
    end else begin
      flags   <= flagsNext;
      en      <= enNext;
      coreBit <= coreNext;
      slvBit  <= slvNext;
      mask    <= maskNext;
      irq     <= |(topStatus & ~mask);
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(ADR_CTRL))  rdData = en;
    if (rdAddr == ADDR_W'(ADR_FLAGS)) rdData = flags;
    if (rdAddr == ADDR_W'(ADR_TOP))   rdData = NUM_CORE'(topStatus);
    if (rdAddr == ADDR_W'(ADR_MASK))  rdData = NUM_CORE'(mask);
  end

  assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlags[0] && !stb.setFlags[0]) |=> !flags[0]);

  assert_sticky_health_R2: assert property (@(posedge clk) disable iff (!rstN)
    (flags[2] && !stb.clrFlags[2] && !stb.softClr) |=> flags[2]);

  assert_unmask_core_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.unmask[0] && !stb.maskSet[0]) |=> !mask[0]);

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.softClr |=> (flags == '0 && !coreBit));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '1) |=> !irq);
endmodule

// File: rtl/intAggTop.sv
module intAggTop
  import intAggPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [5:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [2:0]        rdData,
  input  logic              doneEvt,
  input  logic              contFaultInj,
  input  logic              healthFaultInj,
  input  logic              slvErrEvt,
  input  logic              oscEnable,
  input  logic              reseedEnable,
  input  logic              blockReset,
  input  logic              softReset,
  input  logic              legacyMode,
  input  logic              legacyContEn,
  output logic              irq
);
  aggStrobes_t         stb;
  logic [NUM_CORE-1:0] coreFlags;

  intAggControl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .doneEvt(doneEvt), .contFaultInj(contFaultInj), .healthFaultInj(healthFaultInj),
    .slvErrEvt(slvErrEvt), .oscEnable(oscEnable), .reseedEnable(reseedEnable),
    .blockReset(blockReset), .softReset(softReset),
    .legacyMode(legacyMode), .legacyContEn(legacyContEn), .stb(stb)
  );

  intAggDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .rdData(rdData), .coreFlags(coreFlags), .irq(irq)
  );

  assert_osc_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEnable && !coreFlags[2]) |=> !coreFlags[2]);

  assert_blk_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (blockReset && !coreFlags[1]) |=> !coreFlags[1]);

  assert_legacy_cont_R9: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && !legacyContEn && !coreFlags[1]) |=> !coreFlags[1]);
endmodule

// File: tb/tb_intAggTop.sv
module tb_intAggTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [5:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [2:0] rdData;
  logic doneEvt = 0, contFaultInj = 0, healthFaultInj = 0, slvErrEvt = 0;
  logic oscEnable = 0, reseedEnable = 0, blockReset = 0, softReset = 0;
  logic legacyMode = 0, legacyContEn = 0;
  logic irq;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  intAggTop dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .doneEvt(doneEvt), .contFaultInj(contFaultInj),
    .healthFaultInj(healthFaultInj), .slvErrEvt(slvErrEvt), .oscEnable(oscEnable),
    .reseedEnable(reseedEnable), .blockReset(blockReset), .softReset(softReset),
    .legacyMode(legacyMode), .legacyContEn(legacyContEn), .irq(irq)
  );

  // {en[2:0], inj{health,cont,done}, osc, reseed, legacy, legacyEn, expFlags[2:0], expCore}
  localparam logic [13:0] VEC [9] = '{
    14'b111_001_1100_001_1,
    14'b000_111_1100_111_0,
    14'b010_010_0100_000_0,
    14'b100_100_1000_000_0,
    14'b010_010_1110_000_0,
    14'b010_010_1111_010_1,
    14'b100_111_1110_101_1,
    14'b001_110_1100_110_0,
    14'b011_101_0100_001_1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [2:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulseEvt(input logic [2:0] inj);
    doneEvt = inj[0]; contFaultInj = inj[1]; healthFaultInj = inj[2];
    tick();
    doneEvt = 0; contFaultInj = 0; healthFaultInj = 0;
  endtask

  task automatic pulseSoft();
    softReset = 1'b1;
    tick();
    softReset = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [2:0] v;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rd(3'd3, v); check("R1 mask", v, 3);
    rd(3'd1, v); check("R1 flags", v, 0);
    rd(3'd2, v); check("R1 top status", v, 0);
    rd(3'd0, v); check("R1 enables", v, 0);
    check("R1 irq", irq, 0);

    // R2 R4 R8 R9 table
    for (int i = 0; i < 9; i++) begin
      logic [13:0] t;
      t = VEC[i];
      oscEnable = t[7]; reseedEnable = t[6]; legacyMode = t[5]; legacyContEn = t[4];
      pulseSoft();
      wr(3'd0, {3'b000, t[13:11]});
      pulseEvt(t[10:8]);
      rd(3'd1, v); check($sformatf("R2/R8/R9 flags vec %0d", i), v, t[3:1]);
      rd(3'd2, v); check($sformatf("R4 core bit vec %0d", i), v[0], t[0]);
    end

    oscEnable = 1; reseedEnable = 1; legacyMode = 0; legacyContEn = 0;
    pulseSoft();
    wr(3'd2, 6'd3);
    wr(3'd0, 6'd7);

    // R3 clear and set-wins
    pulseEvt(3'b001);
    rd(3'd1, v); check("R2 done set", v, 1);
    wr(3'd0, 6'b001_111);
    rd(3'd1, v); check("R3 clear done", v, 0);
    rd(3'd0, v); check("R3 enables kept", v, 7);
    wrEn = 1; wrAddr = 3'd0; wrData = 6'b001_111; doneEvt = 1;
    tick();
    wrEn = 0; doneEvt = 0;
    rd(3'd1, v); check("R3 set wins over clear", v, 1);

    // R4 W1C holds until a change
    rd(3'd2, v); check("R4 core recomputed", v[0], 1);
    wr(3'd2, 6'd1);
    rd(3'd2, v); check("R4 core W1C", v[0], 0);
    wr(3'd0, 6'd6);
    rd(3'd2, v); check("R4 enable off", v[0], 0);
    wr(3'd0, 6'd7);
    rd(3'd2, v); check("R4 enable on", v[0], 1);

    // R7 timing and R6 unmask
    check("R7 masked irq", irq, 0);
    wr(3'd4, 6'd1);
    rd(3'd3, v); check("R6 unmask core", v, 2);
    check("R7 irq not yet", irq, 0);
    tick();
    check("R7 irq one clock later", irq, 1);
    rd(3'd4, v); check("R6 unmask reads zero", v, 0);
    rd(3'd5, v); check("R6 mask-set reads zero", v, 0);

    // R5 W1C and slave error
    wr(3'd2, 6'd1);
    rd(3'd2, v); check("R5 W1C core", v, 0);
    check("R7 irq still high", irq, 1);
    tick();
    check("R7 irq falls", irq, 0);
    slvErrEvt = 1; tick(); slvErrEvt = 0;
    rd(3'd2, v); check("R5 slave error set", v, 2);
    tick();
    check("R5 slave error masked", irq, 0);
    wr(3'd3, 6'd0);
    rd(3'd3, v); check("R6 mask write ignored", v, 2);
    wr(3'd4, 6'd2);
    tick();
    check("R5 slave error irq", irq, 1);
    wr(3'd5, 6'd3);
    rd(3'd3, v); check("R6 mask set", v, 3);
    tick();
    check("R6 remask drops irq", irq, 0);
    wr(3'd2, 6'd2);
    rd(3'd2, v); check("R5 W1C slave error", v, 0);

    // R10 soft reset
    pulseEvt(3'b101);
    rd(3'd1, v); check("R10 pre flags", v, 5);
    pulseSoft();
    rd(3'd1, v); check("R10 flags cleared", v, 0);
    rd(3'd2, v); check("R10 core cleared", v, 0);
    rd(3'd0, v); check("R10 enables kept", v, 7);
    rd(3'd3, v); check("R10 mask kept", v, 3);

    // R8 block reset gating
    blockReset = 1;
    pulseEvt(3'b110);
    rd(3'd1, v); check("R8 block reset gate", v, 0);
    blockReset = 0;
    reseedEnable = 0;
    pulseEvt(3'b110);
    rd(3'd1, v); check("R8 reseed gate", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule